// File: doc/BRIEF.md
# Stop-Mode Clock Wake Controller

This block runs the deepest sleep state of a small microcontroller, the one in which both the fast and the slow oscillator are switched off. Software first opens an unlock gate with two key writes and then writes the stop request. Two clock cycles later the controller enters stop mode and drops both oscillator enables and both clock-gate enables.

One non-maskable request wakes the block. So does any of the port interrupt requests whose enable flag is set. On wake the stop request clears and both oscillators are enabled again. Each clock domain then counts its own oscillator-ready pulses, first for a start period and then for a settling period. It reopens its clock gate on its own, without waiting for the other domain. The fast domain reopening returns the controller to run mode. A short status window then marks the cycles in which the processor may still execute before interrupt handling begins.

The two clock-gate enables also act as the per-domain "clock ready" flags that software polls.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset the block is in run mode. `stop_req_o` and `stop_o` are 0, both oscillator enables are 1, both clock-gate enables are 1, `wake_window_o` is 0, and the unlock gate is closed.
- R2: The unlock gate opens only when a key write whose upper nibble (`key_i[7:4]`) is 0x5 is directly followed by a key write whose upper nibble is 0xA. Any other key write closes the gate, and a lone 0xA write does not open it.
- R3: A stop write (`stop_we_i`) made while the gate is closed is ignored. `stop_req_o` and `stop_o` stay 0, and both oscillators and clock gates stay enabled.
- R4: An accepted stop write sets `stop_req_o` after the clock edge that samples it. `stop_o` rises two edges later. While `stop_o` is 1, both oscillator enables and both clock-gate enables are 0.
- R5: In stop mode, `nmi_i`, or any bit of `port_irq_i` whose bit in `port_en_i` is 1, wakes the block on the next edge. Requests on bits whose enable is 0 leave it in stop mode.
- R6: On wake, `stop_o` and `stop_req_o` fall and both oscillator enables rise on the same edge, while both clock gates stay closed.
- R7: The fast clock gate `hs_clk_en_o` reopens on the edge that samples the 8208th `hs_osc_rdy_i` pulse after wake. That count is 16 start pulses followed by 8192 settling pulses. The same edge returns the block to run mode.
- R8: The slow clock gate `ls_clk_en_o` reopens on the edge that samples the 8208th `ls_osc_rdy_i` pulse after wake. It does not depend on the fast domain in any way.
- R9: A wake request already asserted when stop mode is entered ends stop mode on the very next edge, so `stop_o` is 1 for exactly one cycle.
- R10: `wake_window_o` is 1 for exactly the two cycles that begin with the rise of `hs_clk_en_o` after a wake. At all other times it is 0.
- R11: A successful stop entry closes the unlock gate again. A second stop write made without new keys is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_we_i | input | 1 | Key register write strobe |
| key_i | input | 8 | Key write data; the upper nibble is decoded |
| stop_we_i | input | 1 | Stop request write strobe |
| nmi_i | input | 1 | Non-maskable wake request |
| port_irq_i | input | NUM_PORTS | Port interrupt requests |
| port_en_i | input | NUM_PORTS | Per-port wake enable flags |
| hs_osc_rdy_i | input | 1 | Fast oscillator running pulse |
| ls_osc_rdy_i | input | 1 | Slow oscillator running pulse |
| hs_osc_en_o | output | 1 | Fast oscillator enable |
| ls_osc_en_o | output | 1 | Slow oscillator enable |
| hs_clk_en_o | output | 1 | Fast clock gate enable and fast-ready flag |
| ls_clk_en_o | output | 1 | Slow clock gate enable and slow-ready flag |
| stop_req_o | output | 1 | Stop request bit, pending or active |
| stop_o | output | 1 | Stop mode active |
| wake_window_o | output | 1 | Post-release execution window |

## Verification
The assertions check four properties on every cycle:
- In stop mode, oscillators and gates are off.
- The entry delay matches the parameter.
- Masked requests never end stop mode.
- A gate reopens only after exactly the start count plus the settling count of ready pulses, and the window is never open while the fast gate is closed.

Only the bench scenarios can show how the two key writes are ordered, that an unaccepted stop write has no effect, that a held request gives a one-cycle stop, and that the slow domain completes before or after the fast one depending on the pulse rates. The bench covers these with random pulse streams at different densities and random masked request patterns.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_PEND = 2'd1,
    MODE_STOP = 2'd2,
    MODE_WAKE = 2'd3
  } swc_mode_e;

  typedef enum logic [1:0] {
    DOM_RUN    = 2'd0,
    DOM_OFF    = 2'd1,
    DOM_START  = 2'd2,
    DOM_SETTLE = 2'd3
  } swc_dom_e;
endpackage

// File: rtl/swc_key_gate.sv
module swc_key_gate #(
  parameter logic [3:0] KEY_FIRST  = 4'h5,
  parameter logic [3:0] KEY_SECOND = 4'hA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] key_i,
  input  logic       consume_i,
  output logic       armed_o
);
  logic stage_q, armed_q;
  logic [3:0] key_hi;
  logic unused_key_lo;

  assign key_hi        = key_i[7:4];
  assign unused_key_lo = ^key_i[3:0];
  assign armed_o       = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (consume_i) begin
      stage_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (we_i) begin
      if (key_hi == KEY_FIRST) begin
        stage_q <= 1'b1;
        armed_q <= 1'b0;
      end else if (key_hi == KEY_SECOND && stage_q) begin
        stage_q <= 1'b0;
        armed_q <= 1'b1;
      end else begin
        stage_q <= 1'b0;
        armed_q <= 1'b0;
      end
    end
  end

  // R2
  arm_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(we_i && key_i[7:4] == KEY_SECOND));

  // R11
  consume_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !armed_q);
endmodule

// File: rtl/swc_wake_src.sv
module swc_wake_src #(
  parameter int NUM_PORTS = 8
) (
  input  logic                 nmi_i,
  input  logic [NUM_PORTS-1:0] irq_i,
  input  logic [NUM_PORTS-1:0] en_i,
  output logic                 wake_o
);
  logic [NUM_PORTS-1:0] live;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign live[g] = irq_i[g] & en_i[g];
  end

  assign wake_o = nmi_i | (|live);
endmodule

// File: rtl/swc_osc_domain.sv
module swc_osc_domain
  import swc_pkg::*;
#(
  parameter int START_CNT  = 16,
  parameter int SETTLE_CNT = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic wake_i,
  input  logic rdy_i,
  output logic osc_en_o,
  output logic clk_en_o,
  output logic done_o
);
  localparam int MAXC  = (START_CNT > SETTLE_CNT) ? START_CNT : SETTLE_CNT;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int TOTAL = START_CNT + SETTLE_CNT;
  localparam int TW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] START_LAST  = CW'(START_CNT - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CNT - 1);

  swc_dom_e      st_q;
  logic [CW-1:0] cnt_q;

  assign osc_en_o = (st_q != DOM_OFF);
  assign clk_en_o = (st_q == DOM_RUN);
  assign done_o   = (st_q == DOM_SETTLE) && rdy_i && (cnt_q == SETTLE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= DOM_RUN;
      cnt_q <= '0;
    end else if (stop_i) begin
      st_q  <= DOM_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        DOM_OFF: if (wake_i) begin
          st_q  <= DOM_START;
          cnt_q <= '0;
        end
        DOM_START: if (rdy_i) begin
          if (cnt_q == START_LAST) begin
            st_q  <= DOM_SETTLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        DOM_SETTLE: if (rdy_i) begin
          if (cnt_q == SETTLE_LAST) st_q <= DOM_RUN;
          else                      cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // checker: ready pulses seen since the oscillator was re-enabled
  logic [TW-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       seen_q <= '0;
    else if (!osc_en_o)                seen_q <= '0;
    else if (!clk_en_o && rdy_i)       seen_q <= seen_q + 1'b1;
  end

  // R7 R8
  gate_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> seen_q == TW'(TOTAL));

  // R4
  gate_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> osc_en_o);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int ENTRY_DLY    = 2,
  parameter int WIN_LEN      = 2,
  parameter int HS_START_CNT = 16,
  parameter int LS_START_CNT = 16,
  parameter int SETTLE_CNT   = 8192
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 key_we_i,
  input  logic [7:0]           key_i,
  input  logic                 stop_we_i,
  input  logic                 nmi_i,
  input  logic [NUM_PORTS-1:0] port_irq_i,
  input  logic [NUM_PORTS-1:0] port_en_i,
  input  logic                 hs_osc_rdy_i,
  input  logic                 ls_osc_rdy_i,
  output logic                 hs_osc_en_o,
  output logic                 ls_osc_en_o,
  output logic                 hs_clk_en_o,
  output logic                 ls_clk_en_o,
  output logic                 stop_req_o,
  output logic                 stop_o,
  output logic                 wake_window_o
);
  localparam int DW = $clog2(ENTRY_DLY + 1);
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam logic [DW-1:0] DLY_LAST = DW'(ENTRY_DLY - 1);

  swc_mode_e     mode_q;
  logic [DW-1:0] dly_q;
  logic [WW-1:0] win_q;
  logic armed, wake, hs_done, ls_done;
  logic stop_accept, enter_stop, wake_now;

  swc_key_gate i_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (key_we_i),
    .key_i     (key_i),
    .consume_i (enter_stop),
    .armed_o   (armed)
  );

  swc_wake_src #(.NUM_PORTS(NUM_PORTS)) i_src (
    .nmi_i  (nmi_i),
    .irq_i  (port_irq_i),
    .en_i   (port_en_i),
    .wake_o (wake)
  );

  assign stop_accept = stop_we_i && armed && (mode_q == MODE_RUN);
  assign enter_stop  = (mode_q == MODE_PEND) && (dly_q == DLY_LAST);
  assign wake_now    = (mode_q == MODE_STOP) && wake;

  swc_osc_domain #(.START_CNT(HS_START_CNT), .SETTLE_CNT(SETTLE_CNT)) i_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stop_i   (enter_stop),
    .wake_i   (wake_now),
    .rdy_i    (hs_osc_rdy_i),
    .osc_en_o (hs_osc_en_o),
    .clk_en_o (hs_clk_en_o),
    .done_o   (hs_done)
  );

  swc_osc_domain #(.START_CNT(LS_START_CNT), .SETTLE_CNT(SETTLE_CNT)) i_ls (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stop_i   (enter_stop),
    .wake_i   (wake_now),
    .rdy_i    (ls_osc_rdy_i),
    .osc_en_o (ls_osc_en_o),
    .clk_en_o (ls_clk_en_o),
    .done_o   (ls_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      dly_q  <= '0;
    end else begin
      unique case (mode_q)
        MODE_RUN:  if (stop_accept) begin
          mode_q <= MODE_PEND;
          dly_q  <= '0;
        end
        MODE_PEND: if (enter_stop) mode_q <= MODE_STOP;
                   else            dly_q  <= dly_q + 1'b1;
        MODE_STOP: if (wake)       mode_q <= MODE_WAKE;
        MODE_WAKE: if (hs_done)    mode_q <= MODE_RUN;
        default:                   mode_q <= MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         win_q <= '0;
    else if (hs_done)    win_q <= WW'(WIN_LEN);
    else if (win_q != 0) win_q <= win_q - 1'b1;
  end

  assign stop_req_o    = (mode_q == MODE_PEND) || (mode_q == MODE_STOP);
  assign stop_o        = (mode_q == MODE_STOP);
  assign wake_window_o = (win_q != '0);

  logic unused_ls_done;
  assign unused_ls_done = ls_done;

  // checker: cycles since the last accepted stop write
  localparam int SW = $clog2(ENTRY_DLY + 2);
  logic [SW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_q <= SW'(ENTRY_DLY + 1);
    else if (stop_accept)                 since_q <= '0;
    else if (since_q != SW'(ENTRY_DLY+1)) since_q <= since_q + 1'b1;
  end

  // R4
  entry_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> since_q == SW'(ENTRY_DLY));

  // R4
  stop_osc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !hs_osc_en_o && !ls_osc_en_o && !hs_clk_en_o && !ls_clk_en_o);

  // R5
  masked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !nmi_i && ((port_irq_i & port_en_i) == '0)) |=> stop_o);

  // R9
  held_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && nmi_i) |=> !stop_o && hs_osc_en_o && ls_osc_en_o);

  // R10
  window_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_window_o |-> hs_clk_en_o);
endmodule

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
  localparam int NP    = 8;
  localparam int TOTAL = 16 + 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_we = 1'b0;
  logic [7:0] key = '0;
  logic stop_we = 1'b0;
  logic nmi = 1'b0;
  logic [NP-1:0] irq = '0;
  logic [NP-1:0] en = '0;
  logic hs_rdy = 1'b0, ls_rdy = 1'b0;
  logic hs_osc, ls_osc, hs_clk, ls_clk, stop_req, stop_m, win;

  int nvec = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  stop_wake_ctrl i_stop_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .key_we_i(key_we), .key_i(key),
    .stop_we_i(stop_we), .nmi_i(nmi), .port_irq_i(irq), .port_en_i(en),
    .hs_osc_rdy_i(hs_rdy), .ls_osc_rdy_i(ls_rdy),
    .hs_osc_en_o(hs_osc), .ls_osc_en_o(ls_osc), .hs_clk_en_o(hs_clk),
    .ls_clk_en_o(ls_clk), .stop_req_o(stop_req), .stop_o(stop_m),
    .wake_window_o(win)
  );

  function automatic bit gate_open(int pulses);
    return pulses >= TOTAL;
  endfunction

  function automatic bit in_window(int rise, int cyc);
    return (rise >= 0) && (cyc - rise < 2);
  endfunction

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic key_wr(logic [7:0] b);
    key_we = 1'b1; key = b;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic stop_wr();
    stop_we = 1'b1;
    @(negedge clk);
    stop_we = 1'b0;
  endtask

  task automatic check_running(string req);
    chk(req, stop_req, 0); chk(req, stop_m, 0);
    chk(req, hs_osc, 1);   chk(req, ls_osc, 1);
    chk(req, hs_clk, 1);   chk(req, ls_clk, 1);
  endtask

  task automatic expect_ignored(string req);
    stop_wr();
    for (int i = 0; i < 3; i++) begin
      check_running(req);
      @(negedge clk);
    end
  endtask

  task automatic expect_entry();
    stop_wr();
    chk("R4 req set", stop_req, 1); chk("R4 not yet", stop_m, 0);
    @(negedge clk);
    chk("R4 not yet", stop_m, 0);
    @(negedge clk);
    chk("R4 entered", stop_m, 1);
    chk("R4 hs osc off", hs_osc, 0); chk("R4 ls osc off", ls_osc, 0);
    chk("R4 hs gate", hs_clk, 0);    chk("R4 ls gate", ls_clk, 0);
  endtask

  task automatic check_woken();
    chk("R6 stop clr", stop_m, 0);  chk("R6 req clr", stop_req, 0);
    chk("R6 hs osc", hs_osc, 1);    chk("R6 ls osc", ls_osc, 1);
    chk("R6 hs gate shut", hs_clk, 0); chk("R6 ls gate shut", ls_clk, 0);
  endtask

  task automatic run_wake(int hp_pct, int lp_pct);
    int hc = 0, lc = 0, rise = -1, cyc = 0;
    bit hp, lp;
    while (1) begin
      hp = ($urandom_range(99) < hp_pct);
      lp = ($urandom_range(99) < lp_pct);
      hs_rdy = hp; ls_rdy = lp;
      @(negedge clk);
      cyc++;
      if (hc < TOTAL) hc += int'(hp);
      if (lc < TOTAL) lc += int'(lp);
      if (gate_open(hc) && rise < 0) rise = cyc;
      chk("R7 hs gate", hs_clk, gate_open(hc));
      chk("R8 ls gate", ls_clk, gate_open(lc));
      chk("R10 window", win, in_window(rise, cyc));
      chk("R6 osc on", hs_osc & ls_osc, 1);
      if (rise >= 0 && gate_open(lc) && cyc - rise >= 3) break;
    end
    hs_rdy = 1'b0; ls_rdy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_running("R1");
    chk("R1 window", win, 0);

    // R3 no keys at all
    expect_ignored("R3 no key");
    // R2 lone second key
    key_wr(8'hA7);
    expect_ignored("R2 lone A");
    // R2 interrupted sequence
    key_wr(8'h51); key_wr(8'h3C); key_wr(8'hA0);
    expect_ignored("R2 broken seq");
    // R2 armed then disturbed by another write
    key_wr(8'h5F); key_wr(8'hA2); key_wr(8'h12);
    expect_ignored("R2 rewrite");

    // R4 R5 proper arm, masked requests hold, enabled request wakes
    key_wr(8'h57); key_wr(8'hA3);
    expect_entry();
    for (int i = 0; i < 20; i++) begin
      irq = NP'($urandom_range(1, 255));
      en  = ~irq;
      @(negedge clk);
      chk("R5 masked hold", stop_m, 1);
    end
    irq = 8'h10; en = 8'h30;
    @(negedge clk);
    irq = '0; en = '0;
    check_woken();
    run_wake(80, 50);
    check_running("R7 back to run");

    // R11 gate consumed by the previous entry
    expect_ignored("R11 reuse");

    // R9 request already held at entry
    key_wr(8'h50); key_wr(8'hAF);
    nmi = 1'b1;
    expect_entry();
    @(negedge clk);
    nmi = 1'b0;
    chk("R9 one-cycle stop", stop_m, 0);
    check_woken();
    run_wake(100, 100);

    // R8 slow domain finishes first
    key_wr(8'h5A); key_wr(8'hA5);
    expect_entry();
    repeat (5) @(negedge clk);
    chk("R5 stays", stop_m, 1);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    check_woken();
    run_wake(30, 95);
    check_running("R8 both back");
    chk("R10 window closed", win, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule